// File: doc/BRIEF.md
# Ping-Pong Window Capture Buffer

This block takes a stream of 8-bit converter samples and thins it by a fixed ratio, keeping one sample out of every ten. The kept samples fill one of two equal window stores. Each store holds exactly one search window of 500 kept samples, and consecutive windows never overlap. When a window fills, the block marks the end of the window. Capture then moves to the other store, so the finished window stays intact while a downstream detector judges it.

If the detector pulses its flag, the store holding the last completed window is frozen and an interrupt is raised. While the interrupt is up, an external controller reads the frozen store through a plain address/data port. It then pulses a release input, which drops the interrupt and unfreezes the store. Capture never pauses. While one store is frozen, the other store is reused for every new window. A flag that arrives while a store is already frozen cannot be honoured, so it sets a sticky overflow indication instead.

Top module: `winbuf_capture`

## Requirements
- R1: The first valid input after reset is kept, then every tenth valid input after it. Cycles with `smp_valid` low are not counted.
- R2: Kept samples go to addresses 0, 1, 2, ... 499 of the active store. The kept sample written at address 499 closes the window, and `win_end` is high for exactly the one cycle after that write.
- R3: `cap_buf` is 0 after reset and gives the store currently being written. At a window close it flips to the other store, unless that store is frozen. If it is frozen, `cap_buf` does not change and writing restarts at address 0 of the same store.
- R4: A `det_flag` pulse when no store is frozen, and when the last completed window still sits intact in the non-active store, freezes that store. `irq` goes high in the next cycle.
- R5: A frozen store is never written. `rd_data` gives the word at `rd_addr` of the most recently frozen store one cycle after `rd_addr` is applied. Before any freeze, this is store 0.
- R6: A `det_flag` pulse while a store is frozen sets `ovf` in the next cycle. It leaves `irq`, the frozen store and `cap_buf` unchanged.
- R7: A `det_flag` pulse is ignored when no intact completed window exists, and `irq` and `ovf` stay low. This applies before the first window closes, and from a release until the next window close that flips stores.
- R8: A `rd_release` pulse clears `irq` and `ovf` in the next cycle and unfreezes the store, unless a flag in the same cycle sets `ovf`.
- R9: An `rd_addr` of 500 or more gives `rd_data` of 0 one cycle later.
- R10: While `rst_n` is low at a clock edge, `irq`, `ovf`, `win_end`, `cap_buf` and `rd_data` all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Input sample present this cycle |
| smp_data | input | 8 | Input sample value |
| det_flag | input | 1 | One-cycle verdict: last completed window is abnormal |
| rd_release | input | 1 | One-cycle pulse: readout finished, unfreeze |
| rd_addr | input | 9 | Read address into the frozen store |
| rd_data | output | 8 | Read word, one cycle after rd_addr |
| irq | output | 1 | A store is frozen and awaits readout |
| ovf | output | 1 | A flagged window was lost because a store was frozen |
| cap_buf | output | 1 | Index of the store being written |
| win_end | output | 1 | One-cycle pulse after a window closes |

## Verification
The assertions assume `det_flag` and `rd_release` are single-cycle pulses and are never raised in the same cycle. They also assume `det_flag` comes at most once per completed window. The stimulus raises each pulse alone, spaced many cycles apart. Each flag is raised only after the bench has seen `win_end`, except for the flags that probe the ignored cases. Readout addresses change only at falling edges. When no read is in progress, the bench parks the address out of range.

// File: rtl/winbuf_pkg.sv
// Shared types for the ping-pong window capture buffer.
package winbuf_pkg;

    // Outcome of a detector flag in a given cycle.
    typedef enum logic [1:0] {
        FLAG_NONE = 2'd0,  // no flag this cycle
        FLAG_LOCK = 2'd1,  // freeze the store holding the last completed window
        FLAG_OVF  = 2'd2,  // a store is already frozen: record the loss
        FLAG_DROP = 2'd3   // no intact completed window to freeze
    } flag_act_e;

endpackage

// File: rtl/winbuf_decim.sv
// Decimator: passes one of every DECIM valid samples, starting with the
// first valid sample after reset. No filtering. Assumes DECIM >= 1.
module winbuf_decim #(
    parameter int DECIM = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic keep
);
    localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;

    logic [PW-1:0] phase;

    // Keep strobe: sample is kept on phase zero.
    assign keep = in_valid && (phase == '0);

    // Phase counter over valid samples, wrapping at DECIM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (in_valid) begin
            if (phase == PW'(DECIM - 1)) phase <= '0;
            else                         phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/winbuf_ctrl.sv
// Window control: write address, window close, store selection, freeze
// state, interrupt and overflow. Assumes det_flag is a single-cycle pulse
// that refers to the most recently completed window.
module winbuf_ctrl
    import winbuf_pkg::*;
#(
    parameter int WIN_LEN = 500,
    parameter int AW      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep,
    input  logic          det_flag,
    input  logic          rd_release,
    output logic          wr_en,
    output logic          wr_buf,
    output logic [AW-1:0] wr_addr,
    output logic          lock_buf,
    output logic          locked,
    output logic          ovf,
    output logic          win_end
);
    logic      active;
    logic      prev_ok;     // last completed window intact in the idle store
    logic      boundary;
    logic      locked_nxt;
    flag_act_e act;

    assign boundary = keep && (wr_addr == AW'(WIN_LEN - 1));
    assign wr_en    = keep;
    assign wr_buf   = active;

    // Classify this cycle's detector flag.
    always_comb begin
        if (!det_flag)    act = FLAG_NONE;
        else if (locked)  act = FLAG_OVF;
        else if (prev_ok) act = FLAG_LOCK;
        else              act = FLAG_DROP;
    end

    // Freeze state after release and flag are applied.
    assign locked_nxt = (locked && !rd_release) || (act == FLAG_LOCK);

    // Write address: advances per kept sample, wraps at window close.
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_addr <= '0;
        else if (boundary) wr_addr <= '0;
        else if (keep)     wr_addr <= wr_addr + 1'b1;
    end

    // Active store: flips at window close unless the other store is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                        active <= 1'b0;
        else if (boundary && !locked_nxt)  active <= ~active;
    end

    // Intact-window tracking for the idle store.
    always_ff @(posedge clk) begin
        if (!rst_n)                   prev_ok <= 1'b0;
        else if (boundary)            prev_ok <= !locked_nxt;
        else if (act == FLAG_LOCK)    prev_ok <= 1'b0;
    end

    // Freeze flag and which store is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            lock_buf <= 1'b0;
        end else begin
            locked <= locked_nxt;
            if (act == FLAG_LOCK) lock_buf <= ~active;
        end
    end

    // Sticky overflow: set by a lost flag, cleared by release.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (act == FLAG_OVF)  ovf <= 1'b1;
        else if (rd_release)       ovf <= 1'b0;
    end

    // Window-close pulse, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) win_end <= 1'b0;
        else        win_end <= boundary;
    end
endmodule

// File: rtl/winbuf_bank.sv
// One window store: single write port, registered read port.
// Assumes write addresses stay below DEPTH.
module winbuf_bank #(
    parameter int DW    = 8,
    parameter int DEPTH = 500,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rdata <= '0;
        else if (raddr < AW'(DEPTH))   rdata <= mem[raddr];
        else                           rdata <= '0;
    end
endmodule

// File: rtl/winbuf_capture.sv
// Top: ping-pong window capture. Decimates incoming samples, fills two
// alternating window stores, freezes one on a detector flag, and serves
// reads from the frozen store. Assumes WIN_LEN >= 2.
module winbuf_capture #(
    parameter int DW      = 8,
    parameter int DECIM   = 10,
    parameter int WIN_LEN = 500,
    parameter int AW      = $clog2(WIN_LEN),
    parameter int RAW     = $clog2(WIN_LEN + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic           det_flag,
    input  logic           rd_release,
    input  logic [RAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic           irq,
    output logic           ovf,
    output logic           cap_buf,
    output logic           win_end
);
    localparam int NBUF = 2;

    logic          keep;
    logic          wr_en;
    logic          wr_buf;
    logic [AW-1:0] wr_addr;
    logic          lock_buf;
    logic          locked;
    logic          rd_sel_q;
    logic          rd_oob_q;
    logic [DW-1:0] bank_rd [NBUF];

    winbuf_decim #(.DECIM(DECIM)) u_decim (
        .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .keep(keep)
    );

    winbuf_ctrl #(.WIN_LEN(WIN_LEN), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .keep(keep), .det_flag(det_flag),
        .rd_release(rd_release), .wr_en(wr_en), .wr_buf(wr_buf),
        .wr_addr(wr_addr), .lock_buf(lock_buf), .locked(locked),
        .ovf(ovf), .win_end(win_end)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        winbuf_bank #(.DW(DW), .DEPTH(WIN_LEN), .AW(AW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && (wr_buf == 1'(g))),
            .waddr(wr_addr), .wdata(smp_data),
            .raddr(rd_addr[AW-1:0]), .rdata(bank_rd[g])
        );
    end

    // Read-side select and range flag, aligned with the bank read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q <= 1'b0;
            rd_oob_q <= 1'b1;
        end else begin
            rd_sel_q <= lock_buf;
            rd_oob_q <= (rd_addr >= RAW'(WIN_LEN));
        end
    end

    assign rd_data = rd_oob_q ? '0 : bank_rd[rd_sel_q];
    assign irq     = locked;
    assign cap_buf = wr_buf;
endmodule

// File: rtl/winbuf_capture_chk.sv
// Port-level checker for winbuf_capture, attached by bind.
module winbuf_capture_chk #(
    parameter int DW      = 8,
    parameter int WIN_LEN = 500,
    parameter int RAW     = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           det_flag,
    input logic           rd_release,
    input logic [RAW-1:0] rd_addr,
    input logic [DW-1:0]  rd_data,
    input logic           irq,
    input logic           ovf,
    input logic           cap_buf,
    input logic           win_end
);
    p_end_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end);

    p_hold_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $stable(cap_buf));

    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(det_flag));

    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_flag && irq) |=> (ovf && irq));

    p_ovf_needs_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(irq));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_release && !det_flag) |=> (!irq && !ovf));

    p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= RAW'(WIN_LEN)) |=> (rd_data == '0));
endmodule

bind winbuf_capture winbuf_capture_chk #(.DW(DW), .WIN_LEN(WIN_LEN), .RAW(RAW)) u_chk (.*);

// File: tb/sim_winbuf_capture.sv
`timescale 1ns/1ps
module sim_winbuf_capture;
    localparam int WIN = 500;
    localparam int DEC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic       det_flag = 1'b0;
    logic       rd_release = 1'b0;
    logic [8:0] rd_addr = 9'(WIN);
    logic [7:0] rd_data;
    logic       irq, ovf, cap_buf, win_end;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit stream_on = 1'b0;
    bit cmp_on = 1'b0;
    int vcnt = 0;
    int gcyc = 0;

    winbuf_capture u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .det_flag(det_flag), .rd_release(rd_release), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .ovf(ovf), .cap_buf(cap_buf),
        .win_end(win_end)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model state
    int  m_mem [2*WIN];
    int  m_phase, m_addr, m_active, m_locked, m_lockbuf, m_prev, m_ovf;
    int  e_end, e_rd;

    initial for (int i = 0; i < 2*WIN; i++) m_mem[i] = 0;

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_active = 0; m_locked = 0;
            m_lockbuf = 0; m_prev = 0; m_ovf = 0; e_end = 0; e_rd = 0;
        end else begin
            int nl;
            e_rd  = (rd_addr >= WIN) ? 0 : m_mem[m_lockbuf*WIN + int'(rd_addr)];
            e_end = 0;
            nl = rd_release ? 0 : m_locked;
            if (det_flag && m_locked)       m_ovf = 1;
            else if (rd_release)            m_ovf = 0;
            if (det_flag && !m_locked && m_prev) begin
                nl = 1; m_lockbuf = 1 - m_active; m_prev = 0;
            end
            if (smp_valid) begin
                if (m_phase == 0) begin
                    m_mem[m_active*WIN + m_addr] = int'(smp_data);
                    if (m_addr == WIN-1) begin
                        m_addr = 0; e_end = 1;
                        if (nl != 0) m_prev = 0;
                        else begin m_prev = 1; m_active = 1 - m_active; end
                    end else m_addr++;
                end
                m_phase = (m_phase + 1) % DEC;
            end
            m_locked = nl;
        end
    end

    // Per-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4 irq", int'(irq), m_locked);
            chk("R6 ovf", int'(ovf), m_ovf);
            chk("R3 cap_buf", int'(cap_buf), m_active);
            chk("R2 win_end", int'(win_end), e_end);
            chk("R5 rd_data", int'(rd_data), e_rd);
        end
    end

    // Sample source: valid with a regular gap, data = running valid count.
    always @(negedge clk) begin
        if (stream_on) begin
            gcyc++;
            smp_valid = (gcyc % 7) != 3;
            if (smp_valid) begin
                smp_data = 8'(vcnt);
                vcnt++;
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic pulse_flag();
        @(negedge clk); det_flag = 1'b1;
        @(negedge clk); det_flag = 1'b0;
    endtask

    task automatic pulse_release();
        @(negedge clk); rd_release = 1'b1;
        @(negedge clk); rd_release = 1'b0;
    endtask

    task automatic read_at(input int a, output int v);
        @(negedge clk); rd_addr = 9'(a);
        @(negedge clk); v = int'(rd_data);
        rd_addr = 9'(WIN);
    endtask

    task automatic wait_end();
        do @(negedge clk); while (win_end !== 1'b1);
    endtask

    initial begin
        int v;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 irq", int'(irq), 0);
        chk("R10 ovf", int'(ovf), 0);
        chk("R10 cap_buf", int'(cap_buf), 0);
        chk("R10 win_end", int'(win_end), 0);
        chk("R10 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        stream_on = 1'b1;

        // R7: flag before any window closes is ignored
        repeat (100) @(negedge clk);
        pulse_flag();
        chk("R7 early flag irq", int'(irq), 0);
        chk("R7 early flag ovf", int'(ovf), 0);

        // Window 0 closes into store 0; capture moves to store 1
        wait_end();
        chk("R3 flip after w0", int'(cap_buf), 1);
        pulse_flag();
        chk("R4 freeze irq", int'(irq), 1);

        // Window 1 closes while store 0 frozen: stays in store 1
        wait_end();
        chk("R3 stay while frozen", int'(cap_buf), 1);
        pulse_flag();
        chk("R6 overflow set", int'(ovf), 1);
        chk("R6 irq kept", int'(irq), 1);

        // R1/R5: frozen store 0 still holds window 0 (every tenth sample)
        for (int a = 0; a < WIN; a++) begin
            read_at(a, v);
            chk("R1 R5 window0 word", v, (10*a) & 255);
        end
        read_at(WIN, v);
        chk("R9 out of range", v, 0);
        read_at(511, v);
        chk("R9 top address", v, 0);

        // R8: release clears irq and overflow
        pulse_release();
        chk("R8 irq cleared", int'(irq), 0);
        chk("R8 ovf cleared", int'(ovf), 0);

        // R7: no intact window after release until a flipping close
        pulse_flag();
        chk("R7 flag after release", int'(irq), 0);

        // Window 2 closes in store 1; flip to store 0; freeze store 1
        wait_end();
        chk("R3 flip after release", int'(cap_buf), 0);
        pulse_flag();
        chk("R4 freeze store1", int'(irq), 1);
        read_at(0, v);
        chk("R5 window2 first", v, 10000 & 255);
        read_at(WIN-1, v);
        chk("R5 window2 last", v, (10000 + 10*(WIN-1)) & 255);
        pulse_release();
        chk("R8 second release", int'(irq), 0);

        repeat (20) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule